// File: doc/BRIEF.md
# Coulomb Counter with Adaptive Averaging

This block is the digital back end of a battery charge converter. Each time the converter raises its sample strobe, the block takes one signed charge sample. It adds that sample, plus a programmable signed offset, to a 40-bit running charge sum. It also keeps an exponential moving average of the samples and raises two status flags: overload and lock. The analog integrator, the current DAC and the limit comparators sit outside the block. They reach it only as the sample word, the two limit flags and a full-scale indication.

Samples, the offset and the average all use one 16-bit two's-complement format: a sign, 9 integer bits and 6 fractional bits. The sum keeps the same LSB weight. The average weight is w = 2^maw, and each update divides by w+1 in a sequential divider, so the new average appears a fixed number of cycles after the strobe. With dynamic averaging enabled, a large sample-to-sample step or an active limit flag forces w to 1, so the average follows fast transients.

Software reaches the block through a small word-wide register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `coulomb_counter`

## Requirements
- R1: On each cycle with strobe_i high, the sum becomes sum + sample + offset, each sign-extended to 40 bits, and wraps modulo 2^40. The sum is read at address 2 (bits 15:0), address 3 (bits 31:16) and address 4 (bits 39:32, zero-extended).
- R2: The offset register at address 1 (16-bit signed, same format as the sample) reads back as written. It is added on every strobe, even when the sample is zero.
- R3: Writing address 0 with bit 0 set clears the sum. When a strobe falls in the same cycle, the clear wins and the sum is zero afterwards.
- R4: After a strobe, the average at address 5 becomes avg + trunc((sample - avg)/(2^maw + 1)), rounded toward zero. maw is control bits 4:2. The result is readable within 20 cycles of the strobe.
- R5: When control bit 5 (dynamic averaging) is set, the divisor is 2 for any strobe where |sample - previous sample| > 4*DELTA_C, or where hi_lim_i or lo_lim_i is high.
- R6: Writing address 0 with bit 1 set loads the average with the most recent strobed sample.
- R7: Status bit 0 (overload) rises after the 4th consecutive strobe that sees a limit flag together with full_scale_i. It falls after the first strobe that does not see that combination. overload_o mirrors status bit 0.
- R8: Status bit 1 (lock) sets on any strobe that sees a limit flag. While locked, it clears on the 3rd consecutive strobe with no limit flag and |sample - previous sample| < 2*DELTA_C. Any other strobe restarts that count. locked_o mirrors status bit 1.
- R9: After reset, the sum, average, offset and status read zero. Control address 0 reads back maw in bits 4:2 and the dynamic-averaging enable in bit 5, with bits 1:0 reading zero.
- R10: Without a strobe, the sample, limit and full-scale inputs have no effect on the sum, the average or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | One-cycle sample strobe |
| sample_i | input | 16 | Signed charge sample, sign + 9 integer + 6 fraction bits |
| hi_lim_i | input | 1 | High-limit comparator flag |
| lo_lim_i | input | 1 | Low-limit comparator flag |
| full_scale_i | input | 1 | Current DAC at full scale |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| overload_o | output | 1 | Overload flag |
| locked_o | output | 1 | Lock flag |

## Verification
A bad sum register shows up in the sum words on the very next read after a strobe, and the error then persists, because the sum only accumulates. A fault in the divider or in the weight selection does not show until the average word updates about 19 cycles after the strobe. From then on it skews every later average, so the bench compares the average after each strobe. A miscount in the overload or lock counters shows in the status word exactly on the strobe where the 4th or 3rd qualifying period should flip it, so the directed runs step through these counts one strobe at a time.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 3;
  localparam int A_CTRL    = 0;
  localparam int A_OFFSET  = 1;
  localparam int A_SUM0    = 2;
  localparam int A_AVG     = 5;
  localparam int A_STATUS  = 6;
  localparam int CB_CLR    = 0;
  localparam int CB_RELOAD = 1;
  localparam int CB_MAW    = 2;
  localparam int CB_DYN    = 5;
endpackage

// File: rtl/cc_accum.sv
module cc_accum #(
  parameter int SUM_W  = 40,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] offset_i,
  output logic [SUM_W-1:0]  sum_o
);
  localparam int EXT_W = SUM_W - DATA_W;
  logic [SUM_W-1:0] sum_q, smp_ext, off_ext;

  assign smp_ext = {{EXT_W{sample_i[DATA_W-1]}}, sample_i};
  assign off_ext = {{EXT_W{offset_i[DATA_W-1]}}, offset_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sum_q <= '0;
    else if (clr_i)    sum_q <= '0;
    else if (strobe_i) sum_q <= sum_q + smp_ext + off_ext;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/cc_divider.sv
module cc_divider #(
  parameter int N = 17,
  parameter int D = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] dvd_i,
  input  logic [D-1:0] dvs_i,
  output logic         done_o,
  output logic [N-1:0] quo_o
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt_q;
  logic [D:0]    rem_q, rem_sh, rem_nx;
  logic [N-1:0]  quo_q;
  logic [D-1:0]  dvs_q;
  logic          busy_q, done_q, ge;

  always_comb begin
    rem_sh = {rem_q[D-1:0], quo_q[N-1]};
    ge     = rem_sh >= {1'b0, dvs_q};
    rem_nx = ge ? rem_sh - {1'b0, dvs_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; rem_q <= '0; quo_q <= '0; dvs_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CW'(N);
      rem_q  <= '0;
      quo_q  <= dvd_i;
      dvs_q  <= dvs_i;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= rem_nx;
      quo_q <= {quo_q[N-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/cc_avg.sv
module cc_avg #(
  parameter int DATA_W = 16,
  parameter int MAW_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              fast_i,
  input  logic [MAW_W-1:0]  maw_i,
  input  logic              reload_i,
  input  logic [DATA_W-1:0] last_i,
  output logic [DATA_W-1:0] avg_o
);
  localparam int N = DATA_W + 1;
  localparam int D = 1 << MAW_W;

  logic [DATA_W-1:0] avg_q;
  logic [N-1:0]      diff, mag, quo, qs;
  logic [D-1:0]      dvs;
  logic [MAW_W-1:0]  shift;
  logic              neg_q, done;

  always_comb begin
    diff  = {sample_i[DATA_W-1], sample_i} - {avg_q[DATA_W-1], avg_q};
    mag   = diff[N-1] ? (~diff + 1'b1) : diff;
    shift = fast_i ? '0 : maw_i;
    dvs   = (D'(1) << shift) + D'(1);
    qs    = neg_q ? (~quo + 1'b1) : quo;
  end

  cc_divider #(.N(N), .D(D)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (strobe_i),
    .dvd_i   (mag),
    .dvs_i   (dvs),
    .done_o  (done),
    .quo_o   (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q <= '0;
      neg_q <= 1'b0;
    end else begin
      if (strobe_i) neg_q <= diff[N-1];
      if (reload_i)  avg_q <= last_i;
      else if (done) avg_q <= avg_q + qs[DATA_W-1:0];
    end
  end

  assign avg_o = avg_q;
endmodule

// File: rtl/cc_flags.sv
module cc_flags #(
  parameter int STEP_W     = 17,
  parameter int DELTA_C    = 16,
  parameter int OVL_LIMIT  = 3,
  parameter int SAFE_LIMIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              limit_i,
  input  logic              full_scale_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              overload_o,
  output logic              locked_o
);
  localparam int OW = $clog2(OVL_LIMIT + 2);
  localparam int SW = $clog2(SAFE_LIMIT + 1) + 1;
  localparam logic [STEP_W-1:0] SAFE_TH = STEP_W'(2 * DELTA_C);

  logic [OW-1:0] ovl_q;
  logic [SW-1:0] safe_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovl_q <= '0;
    end else if (strobe_i) begin
      if (!(limit_i && full_scale_i))     ovl_q <= '0;
      else if (ovl_q != OW'(OVL_LIMIT + 1)) ovl_q <= ovl_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      safe_q <= '0;
    end else if (strobe_i) begin
      if (limit_i) begin
        lock_q <= 1'b1;
        safe_q <= '0;
      end else if (lock_q && step_i < SAFE_TH) begin
        if (safe_q == SW'(SAFE_LIMIT)) begin
          lock_q <= 1'b0;
          safe_q <= '0;
        end else begin
          safe_q <= safe_q + 1'b1;
        end
      end else begin
        safe_q <= '0;
      end
    end
  end

  assign overload_o = ovl_q > OW'(OVL_LIMIT);
  assign locked_o   = lock_q;
endmodule

// File: rtl/coulomb_counter.sv
module coulomb_counter
  import cc_pkg::*;
#(
  parameter int SUM_W   = 40,
  parameter int DATA_W  = 16,
  parameter int MAW_W   = 3,
  parameter int DELTA_C = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              hi_lim_i,
  input  logic              lo_lim_i,
  input  logic              full_scale_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              overload_o,
  output logic              locked_o
);
  localparam int STEP_W = DATA_W + 1;
  localparam int NWORD  = (SUM_W + REG_W - 1) / REG_W;
  localparam int PAD_W  = NWORD * REG_W - SUM_W;
  localparam logic [STEP_W-1:0] BIG_TH = STEP_W'(4 * DELTA_C);

  logic [MAW_W-1:0]  maw_q;
  logic              dyn_q;
  logic [DATA_W-1:0] offset_q, prev_q, avg_q;
  logic [SUM_W-1:0]  sum_q;
  logic [NWORD*REG_W-1:0] sum_ext;
  logic [STEP_W-1:0] step_diff, step_mag;
  logic              ctrl_wr, clr_cmd, reload_cmd, limit, fast;

  assign ctrl_wr    = reg_we_i && reg_addr_i == ADDR_W'(A_CTRL);
  assign clr_cmd    = ctrl_wr && reg_wdata_i[CB_CLR];
  assign reload_cmd = ctrl_wr && reg_wdata_i[CB_RELOAD];
  assign limit      = hi_lim_i || lo_lim_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maw_q <= '0; dyn_q <= 1'b0; offset_q <= '0; prev_q <= '0;
    end else begin
      if (ctrl_wr) begin
        maw_q <= reg_wdata_i[CB_MAW +: MAW_W];
        dyn_q <= reg_wdata_i[CB_DYN];
      end
      if (reg_we_i && reg_addr_i == ADDR_W'(A_OFFSET)) offset_q <= reg_wdata_i[DATA_W-1:0];
      if (strobe_i) prev_q <= sample_i;
    end
  end

  always_comb begin
    step_diff = {sample_i[DATA_W-1], sample_i} - {prev_q[DATA_W-1], prev_q};
    step_mag  = step_diff[STEP_W-1] ? (~step_diff + 1'b1) : step_diff;
    fast      = dyn_q && (limit || step_mag > BIG_TH);
  end

  cc_accum #(.SUM_W(SUM_W), .DATA_W(DATA_W)) u_accum (
    .clk_i, .rst_ni, .clr_i(clr_cmd), .strobe_i,
    .sample_i, .offset_i(offset_q), .sum_o(sum_q)
  );

  cc_avg #(.DATA_W(DATA_W), .MAW_W(MAW_W)) u_avg (
    .clk_i, .rst_ni, .strobe_i, .sample_i, .fast_i(fast),
    .maw_i(maw_q), .reload_i(reload_cmd), .last_i(prev_q), .avg_o(avg_q)
  );

  cc_flags #(.STEP_W(STEP_W), .DELTA_C(DELTA_C)) u_flags (
    .clk_i, .rst_ni, .strobe_i, .limit_i(limit), .full_scale_i,
    .step_i(step_mag), .overload_o, .locked_o
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign sum_ext = {{PAD_W{1'b0}}, sum_q};
    end else begin : g_nopad
      assign sum_ext = sum_q;
    end
  endgenerate

  always_comb begin
    reg_rdata_o = '0;
    unique case (int'(reg_addr_i))
      A_CTRL:   begin
                  reg_rdata_o[CB_MAW +: MAW_W] = maw_q;
                  reg_rdata_o[CB_DYN]          = dyn_q;
                end
      A_OFFSET: reg_rdata_o = REG_W'(offset_q);
      A_AVG:    reg_rdata_o = REG_W'(avg_q);
      A_STATUS: reg_rdata_o = {{(REG_W-2){1'b0}}, locked_o, overload_o};
      default:  begin
                  for (int k = 0; k < NWORD; k++)
                    if (int'(reg_addr_i) == A_SUM0 + k) reg_rdata_o = sum_ext[k*REG_W +: REG_W];
                end
    endcase
  end
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
  parameter int SUM_W  = 40,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic [DATA_W-1:0] sample_i,
  input logic              hi_lim_i,
  input logic              lo_lim_i,
  input logic              full_scale_i,
  input logic              clr_i,
  input logic              reload_i,
  input logic [DATA_W-1:0] offset_i,
  input logic [DATA_W-1:0] prev_i,
  input logic [DATA_W-1:0] avg_i,
  input logic [SUM_W-1:0]  sum_i,
  input logic              overload_i,
  input logic              locked_i
);
  localparam int EXT_W = SUM_W - DATA_W;

  p_sum_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !clr_i |=> sum_i == $past(sum_i) + {{EXT_W{$past(sample_i[DATA_W-1])}}, $past(sample_i)}
                                     + {{EXT_W{$past(offset_i[DATA_W-1])}}, $past(offset_i)});

  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sum_i == '0);

  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> avg_i == $past(prev_i));

  p_ovl_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overload_i) |-> $past(strobe_i && full_scale_i && (hi_lim_i || lo_lim_i)));

  p_lock_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (hi_lim_i || lo_lim_i) |=> locked_i);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i && !clr_i |=> $stable(sum_i) && $stable(overload_i) && $stable(locked_i));
endmodule

bind coulomb_counter cc_checker #(.SUM_W(SUM_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .strobe_i, .sample_i, .hi_lim_i, .lo_lim_i, .full_scale_i,
  .clr_i(clr_cmd), .reload_i(reload_cmd), .offset_i(offset_q), .prev_i(prev_q),
  .avg_i(avg_q), .sum_i(sum_q), .overload_i(overload_o), .locked_i(locked_o)
);

// File: tb/tb_coulomb_counter.sv
module tb_coulomb_counter;
  localparam int CLK_PERIOD = 10;
  localparam int DELTA_C    = 16;

  logic        clk = 0, rst_ni = 0;
  logic        strobe = 0, hi = 0, lo = 0, fs = 0, we = 0;
  logic [15:0] sample = 0, wdata = 0, rdata;
  logic [2:0]  addr = 0;
  logic        ovl, lck;

  int errors = 0, checks = 0;

  // bench model
  logic [39:0] m_sum = 0;
  int m_avg = 0, m_prev = 0, m_off = 0, m_maw = 0, m_dyn = 0;
  int m_ocnt = 0, m_scnt = 0;
  bit m_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coulomb_counter dut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .sample_i(sample),
    .hi_lim_i(hi), .lo_lim_i(lo), .full_scale_i(fs), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .overload_o(ovl), .locked_o(lck)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); addr = 3'(a); #1 d = rdata;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = 3'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  function automatic int avg_next(int a, int s, int sh);
    int diff = s - a;
    int q = (diff < 0 ? -diff : diff) / ((1 << sh) + 1);
    return a + (diff < 0 ? -q : q);
  endfunction

  function automatic int sx16(logic [15:0] v);
    return int'(signed'(v));
  endfunction

  task automatic model_strobe(int s, bit h, bit l, bit f, bit clr);
    int step = s - m_prev;
    int sh;
    bit lim = h || l;
    if (step < 0) step = -step;
    sh = (m_dyn != 0 && (lim || step > 4*DELTA_C)) ? 0 : m_maw;
    m_avg = avg_next(m_avg, s, sh);
    if (clr) m_sum = 0;
    else m_sum = m_sum + 40'(longint'(s)) + 40'(longint'(m_off));
    if (lim && f) m_ocnt = (m_ocnt < 4) ? m_ocnt + 1 : 4; else m_ocnt = 0;
    if (lim) begin m_lock = 1; m_scnt = 0; end
    else if (m_lock && step < 2*DELTA_C) begin
      if (m_scnt == 2) begin m_lock = 0; m_scnt = 0; end else m_scnt++;
    end else m_scnt = 0;
    m_prev = s;
  endtask

  task automatic do_strobe(int s, bit h, bit l, bit f, bit clr = 0);
    @(negedge clk);
    strobe = 1; sample = 16'(s); hi = h; lo = l; fs = f;
    if (clr) begin we = 1; addr = 0; wdata = 16'(((m_dyn & 1) << 5) | (m_maw << 2) | 1); end
    @(negedge clk);
    strobe = 0; we = 0; hi = 0; lo = 0; fs = 0;
    model_strobe(s, h, l, f, clr);
    repeat (22) @(negedge clk);
  endtask

  task automatic set_ctrl(int maw, int dyn, bit reload);
    m_maw = maw; m_dyn = dyn;
    wr(0, 16'((dyn << 5) | (maw << 2) | (reload ? 2 : 0)));
    if (reload) m_avg = m_prev;
  endtask

  task automatic check_all(string tag);
    logic [15:0] d;
    rd(2, d); chk(d == m_sum[15:0],  {tag, " R1 sum[15:0]"},  d, m_sum[15:0]);
    rd(3, d); chk(d == m_sum[31:16], {tag, " R1 sum[31:16]"}, d, m_sum[31:16]);
    rd(4, d); chk(d == {8'h0, m_sum[39:32]}, {tag, " R1 sum[39:32]"}, d, m_sum[39:32]);
    rd(5, d); chk(d == 16'(m_avg), {tag, " R4 avg"}, d, 16'(m_avg));
    rd(6, d); chk(d == {14'h0, m_lock, m_ocnt >= 4}, {tag, " R7 R8 status"}, d, {m_lock, m_ocnt >= 4});
    chk(ovl == (m_ocnt >= 4), {tag, " R7 overload_o"}, ovl, m_ocnt >= 4);
    chk(lck == m_lock, {tag, " R8 locked_o"}, lck, m_lock);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed_c0c0));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R9 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a, d); chk(d == 16'h0, "R9 reset readout", d, 0);
    end
    set_ctrl(5, 1, 0);
    rd(0, d); chk(d == 16'h0034, "R9 ctrl readback", d, 16'h0034);

    // R2 offset alone
    m_off = 100; wr(1, 16'(m_off));
    rd(1, d); chk(d == 16'd100, "R2 offset readback", d, 100);
    set_ctrl(0, 0, 0);
    do_strobe(0, 0, 0, 0); check_all("R2 zero sample");
    m_off = -37; wr(1, 16'(m_off));
    do_strobe(0, 0, 0, 0); check_all("R2 negative offset");

    // R4 plain averaging, several weights
    for (int w = 0; w < 8; w++) begin
      set_ctrl(w, 0, 0);
      do_strobe(3000 - w*900, 0, 0, 0); check_all("R4 weight sweep");
    end

    // R5 dynamic weight on big step and on limit
    set_ctrl(3, 1, 0);
    do_strobe(m_prev + 10, 0, 0, 0);    check_all("R5 small step keeps weight");
    do_strobe(m_prev + 2000, 0, 0, 0);  check_all("R5 big step forces w=1");
    do_strobe(m_prev + 5, 1, 0, 0);     check_all("R5 hi limit forces w=1");
    set_ctrl(3, 0, 0);
    do_strobe(m_prev - 2000, 0, 0, 0);  check_all("R4 big step dyn off");

    // R6 reload
    set_ctrl(3, 0, 1);
    rd(5, d); chk(d == 16'(m_avg), "R6 reload avg", d, 16'(m_avg));

    // R3 clear, and clear wins over strobe
    wr(0, 16'((m_maw << 2) | 1)); m_sum = 0;
    rd(2, d); chk(d == 0, "R3 clear", d, 0);
    do_strobe(500, 0, 0, 0); check_all("R3 after clear");
    do_strobe(700, 0, 0, 0, 1); check_all("R3 clear wins over strobe");

    // R7 overload counting
    for (int i = 0; i < 5; i++) begin
      do_strobe(m_prev, 1, 0, 1); check_all("R7 overload run");
    end
    do_strobe(m_prev, 0, 1, 0); check_all("R7 drop without full scale");
    do_strobe(m_prev, 0, 0, 0); check_all("R8 unlock count 1");

    // R8 lock release, interrupted by an unsafe step
    do_strobe(m_prev + 100, 0, 0, 0); check_all("R8 unsafe step restarts");
    do_strobe(m_prev + 5, 0, 0, 0);   check_all("R8 safe 1");
    do_strobe(m_prev - 5, 0, 0, 0);   check_all("R8 safe 2");
    do_strobe(m_prev + 31, 0, 0, 0);  check_all("R8 safe 3 clears");
    do_strobe(m_prev, 0, 1, 0);       check_all("R8 lo limit sets");

    // R10 inputs without strobe
    @(negedge clk); sample = 16'h7fff; hi = 1; lo = 1; fs = 1;
    repeat (25) @(negedge clk);
    hi = 0; lo = 0; fs = 0;
    check_all("R10 no strobe");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int s = int'($urandom_range(4000)) - 2000;
      bit h = ($urandom_range(9) == 0);
      bit l = ($urandom_range(9) == 0);
      bit f = $urandom_range(1);
      if (i % 15 == 0) begin
        m_off = int'($urandom_range(2000)) - 1000; wr(1, 16'(m_off));
        set_ctrl($urandom_range(7), $urandom_range(1), 0);
      end
      if ($urandom_range(3) == 0) s = m_prev + int'($urandom_range(60)) - 30;
      do_strobe(s, h, l, f); check_all("R1 R4 random");
    end

    // large samples to move the upper words
    set_ctrl(2, 0, 0);
    for (int i = 0; i < 20; i++) begin
      do_strobe(-32768, 0, 0, 0); check_all("R1 large negative");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule